// File: doc/BRIEF.md
# Seven-Source Priority Interrupt Controller

This block gathers interrupt events from seven sources: two external pins and five internal event strobes (three timers, an analog comparator and a serial port). Each event sets a request flag. The flag stays set until the CPU accepts that source or software clears it. A per-source enable mask and a global enable decide whether a pending flag raises the interrupt line. A fixed priority encoder turns the most urgent pending source into a vector code. When the CPU accepts the request, the controller drops the global enable and clears only the flag it served. Two sources, the comparator and the third timer, share one vector level. The comparator is served first within that level, and each keeps its own flag.

The two external pins are asynchronous. Each pin passes through a synchroniser, and only a high-to-low transition on it counts as an event. A separate wake mask, independent of both enable paths, drives a wake line that brings the core out of its low-power hold state. Because the flags may be meaningless after power-up, a clear command removes any chosen set of flags in one cycle.

The interrupt line and the accept input work as a valid/ready pair, with the vector as the payload. `irq_o` is valid, and the vector is meaningful only while `irq_o` is high. While no accept arrives, the vector may be replaced by a newly pending source of higher priority. The controller holds the request until `ack_i` is seen high at a clock edge while `irq_o` is high. An accept pulse that arrives while `irq_o` is low is discarded.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, `flags_o`, `gie_o`, `irq_o` and `wake_o` are all 0.
- R2: A high level on an internal event input at a clock edge sets its flag, visible after that edge. The flag bit order is: 0 external pin 0, 1 timer 0, 2 timer 2, 3 comparator, 4 timer 3, 5 external pin 1, 6 serial.
- R3: A pin flag is set only by a falling edge on its pin, never by a rising edge or a steady level. The default synchroniser has two stages. With it, the flag appears after the third rising clock edge from the edge that first samples the low level.
- R4: `irq_o` is high exactly when `gie_o` is high and at least one flag is set whose bit in `src_en_i` is also set.
- R5: `irq_vec_o` codes the highest-priority enabled pending source, lowest flag bit first. The codes are: pin 0 → 0, timer 0 → 1, timer 2 → 2, comparator or timer 3 → 3, pin 1 → 4, serial → 5. When both comparator and timer 3 are pending, the comparator is the one served.
- R6: `ack_i` high at an edge while `irq_o` is high clears `gie_o` and the served flag only. `ack_i` while `irq_o` is low changes nothing.
- R7: `clr_i` clears every flag selected in `clr_mask_i` at the next edge. An event for the same source in that cycle wins, and its flag stays set.
- R8: `wake_o` is high exactly when some set flag has its bit set in `wake_mask_i`, regardless of `src_en_i` and `gie_o`.
- R9: `gie_set_i` sets `gie_o` at the next edge, unless an accept happens in the same cycle. In that case `gie_o` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| edge_pin0_i | input | 1 | External pin, source 0, falling-edge event |
| edge_pin1_i | input | 1 | External pin, source 5, falling-edge event |
| tmr0_evt_i | input | 1 | Timer 0 event strobe, source 1 |
| tmr2_evt_i | input | 1 | Timer 2 event strobe, source 2 |
| cmp_evt_i | input | 1 | Comparator event strobe, source 3 |
| tmr3_evt_i | input | 1 | Timer 3 event strobe, source 4 |
| ser_evt_i | input | 1 | Serial port event strobe, source 6 |
| src_en_i | input | 7 | Per-source interrupt enables |
| gie_set_i | input | 1 | Set the global enable |
| clr_i | input | 1 | Clear-flags command |
| clr_mask_i | input | 7 | Flags cleared by the command |
| wake_mask_i | input | 7 | Per-source hold-release mask |
| ack_i | input | 1 | CPU accept of the current request |
| irq_o | output | 1 | Interrupt request (valid) |
| irq_vec_o | output | 3 | Vector code of the request |
| gie_o | output | 1 | Global enable state |
| flags_o | output | 7 | Request flags |
| wake_o | output | 1 | Hold-mode release |

## Verification
Several patterns are applied, each separating a different kind of error. Simultaneous events on all sources, accepted one at a time, expose priority order and the comparator-over-timer-3 tie inside the shared level. Pin pulses, rising edges and held levels check that only falling edges count and that they arrive at the synchroniser's latency. Clear commands that overlap an event, and accept pulses sent while no request is up, show whether set-over-clear holds and whether stray accepts are ignored. A long pseudo-random run mixes enables, wake masks and accepts, and a behavioural model compares the outputs with its own result on every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC  = 7;
  localparam int VEC_W = 3;
  localparam int NPIN  = 2;

  localparam int SRC_PIN0 = 0;
  localparam int SRC_TMR0 = 1;
  localparam int SRC_TMR2 = 2;
  localparam int SRC_CMP  = 3;
  localparam int SRC_TMR3 = 4;
  localparam int SRC_PIN1 = 5;
  localparam int SRC_SER  = 6;

  typedef logic [NSRC-1:0] src_vec_t;

  // comparator and timer 3 fold onto one level
  function automatic logic [VEC_W-1:0] vec_of(input int idx);
    if (idx <= SRC_CMP) return VEC_W'(idx);
    return VEC_W'(idx - 1);
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  // chain[0] newest sample, chain[STAGES] previous synchronised level
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], pin_i};
  end

  assign fall_o = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_o[g] <= 1'b0;
      else        flags_o[g] <= set_i[g] | (flags_o[g] & ~clr_i[g]);
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]     pend_i,
  output logic             any_o,
  output logic [N-1:0]     grant_o,
  output logic [VEC_W-1:0] vec_o
);
  int sel;

  always_comb begin
    sel = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) sel = i;
    end
    for (int i = 0; i < N; i++) begin
      grant_o[i] = pend_i[i] && (sel == i);
    end
  end

  assign any_o = |pend_i;
  assign vec_o = vec_of(sel);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_pin0_i,
  input  logic             edge_pin1_i,
  input  logic             tmr0_evt_i,
  input  logic             tmr2_evt_i,
  input  logic             cmp_evt_i,
  input  logic             tmr3_evt_i,
  input  logic             ser_evt_i,
  input  logic [NSRC-1:0]  src_en_i,
  input  logic             gie_set_i,
  input  logic             clr_i,
  input  logic [NSRC-1:0]  clr_mask_i,
  input  logic [NSRC-1:0]  wake_mask_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic             gie_o,
  output logic [NSRC-1:0]  flags_o,
  output logic             wake_o
);
  logic [NPIN-1:0] pins, falls;
  src_vec_t        set_v, clr_v, pend, grant;
  logic            any_pend, accept, gie_q;

  assign pins = {edge_pin1_i, edge_pin0_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (pins[g]),
      .fall_o(falls[g])
    );
  end

  always_comb begin
    set_v           = '0;
    set_v[SRC_PIN0] = falls[0];
    set_v[SRC_TMR0] = tmr0_evt_i;
    set_v[SRC_TMR2] = tmr2_evt_i;
    set_v[SRC_CMP]  = cmp_evt_i;
    set_v[SRC_TMR3] = tmr3_evt_i;
    set_v[SRC_PIN1] = falls[1];
    set_v[SRC_SER]  = ser_evt_i;
  end

  assign pend   = flags_o & src_en_i;
  assign irq_o  = gie_q & any_pend;
  assign accept = ack_i & irq_o;
  assign clr_v  = ({NSRC{clr_i}} & clr_mask_i) | ({NSRC{accept}} & grant);

  irq_prio_enc #(.N(NSRC)) u_enc (
    .pend_i (pend),
    .any_o  (any_pend),
    .grant_o(grant),
    .vec_o  (irq_vec_o)
  );

  irq_flag_bank #(.N(NSRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .flags_o(flags_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gie_q <= 1'b0;
    else if (accept)    gie_q <= 1'b0;
    else if (gie_set_i) gie_q <= 1'b1;
  end

  assign gie_o  = gie_q;
  assign wake_o = |(flags_o & wake_mask_i);
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_i,
  input logic       gie_set_i,
  input logic       tmr0_evt_i,
  input logic       ser_evt_i,
  input logic       clr_i,
  input logic       clr_ser_i,
  input logic       irq_o,
  input logic [2:0] irq_vec_o,
  input logic       gie_o,
  input logic [6:0] flags_o,
  input logic       wake_o
);
  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr0_evt_i |=> flags_o[1]);

  p_irq_needs_gie_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> gie_o);

  p_vec_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_vec_o <= 3'd5));

  p_ack_clears_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> !gie_o);

  p_ack_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o && !gie_set_i) |=> $stable(gie_o));

  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && clr_ser_i && !ser_evt_i) |=> !flags_o[6]);

  p_wake_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (|flags_o));

  p_gie_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_set_i && !(ack_i && irq_o)) |=> gie_o);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack_i     (ack_i),
  .gie_set_i (gie_set_i),
  .tmr0_evt_i(tmr0_evt_i),
  .ser_evt_i (ser_evt_i),
  .clr_i     (clr_i),
  .clr_ser_i (clr_mask_i[6]),
  .irq_o     (irq_o),
  .irq_vec_o (irq_vec_o),
  .gie_o     (gie_o),
  .flags_o   (flags_o),
  .wake_o    (wake_o)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic edge_pin0_i = 1'b1, edge_pin1_i = 1'b1;
  logic tmr0_evt_i = 0, tmr2_evt_i = 0, cmp_evt_i = 0, tmr3_evt_i = 0, ser_evt_i = 0;
  logic [6:0] src_en_i = '0, clr_mask_i = '0, wake_mask_i = '0;
  logic gie_set_i = 0, clr_i = 0, ack_i = 0;
  logic irq_o, gie_o, wake_o;
  logic [2:0] irq_vec_o;
  logic [6:0] flags_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .edge_pin0_i(edge_pin0_i), .edge_pin1_i(edge_pin1_i),
    .tmr0_evt_i(tmr0_evt_i), .tmr2_evt_i(tmr2_evt_i), .cmp_evt_i(cmp_evt_i),
    .tmr3_evt_i(tmr3_evt_i), .ser_evt_i(ser_evt_i),
    .src_en_i(src_en_i), .gie_set_i(gie_set_i), .clr_i(clr_i),
    .clr_mask_i(clr_mask_i), .wake_mask_i(wake_mask_i), .ack_i(ack_i),
    .irq_o(irq_o), .irq_vec_o(irq_vec_o), .gie_o(gie_o),
    .flags_o(flags_o), .wake_o(wake_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [6:0] m_flags;
  bit       m_gie;
  bit       h0[$] = '{1'b1, 1'b1, 1'b1};
  bit       h1[$] = '{1'b1, 1'b1, 1'b1};

  function automatic int first_pending(input bit [6:0] p);
    for (int i = 0; i < 7; i++) if (p[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flags = '0;
      m_gie   = 0;
      h0 = '{1'b1, 1'b1, 1'b1};
      h1 = '{1'b1, 1'b1, 1'b1};
    end else begin
      bit [6:0] setb, clrb, pend;
      bit irq;
      int acc;
      setb = '0;
      setb[0] = (h0[0] == 1'b1) && (h0[1] == 1'b0);
      setb[5] = (h1[0] == 1'b1) && (h1[1] == 1'b0);
      setb[1] = tmr0_evt_i; setb[2] = tmr2_evt_i; setb[3] = cmp_evt_i;
      setb[4] = tmr3_evt_i; setb[6] = ser_evt_i;
      h0.push_back(edge_pin0_i); void'(h0.pop_front());
      h1.push_back(edge_pin1_i); void'(h1.pop_front());
      pend = m_flags & src_en_i;
      irq  = m_gie && (pend != 0);
      acc  = first_pending(pend);
      clrb = clr_i ? clr_mask_i : 7'd0;
      if (irq && ack_i) clrb[acc] = 1'b1;
      m_flags = (m_flags & ~clrb) | setb;
      if (irq && ack_i) m_gie = 0;
      else if (gie_set_i) m_gie = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit [6:0] pend;
      bit e_irq;
      int acc, e_vec;
      pend  = m_flags & src_en_i;
      e_irq = m_gie && (pend != 0);
      acc   = first_pending(pend);
      e_vec = (acc <= 3) ? acc : acc - 1;
      check(flags_o == m_flags, "R2 R3 R7 flags", flags_o, m_flags);
      check(gie_o == m_gie, "R6 R9 gie", gie_o, m_gie);
      check(irq_o == e_irq, "R4 irq", irq_o, e_irq);
      if (e_irq) check(irq_vec_o == e_vec[2:0], "R5 vector", irq_vec_o, e_vec);
      check(wake_o == ((m_flags & wake_mask_i) != 0), "R8 wake", wake_o,
            (m_flags & wake_mask_i) != 0);
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset state
    check(flags_o == 0 && !gie_o && !irq_o && !wake_o, "R1 reset outputs",
          {flags_o, gie_o, irq_o, wake_o}, 0);
    rst_n = 1;
    tick(1);
    check(flags_o == 0 && !gie_o && !irq_o && !wake_o, "R1 after release",
          {flags_o, gie_o, irq_o, wake_o}, 0);

    // R2 events with enables off; R8 wake ignores enables
    wake_mask_i = 7'b0000100;
    tmr0_evt_i = 1; tick(1); tmr0_evt_i = 0;
    check(flags_o == 7'b0000010, "R2 timer0 flag", flags_o, 7'b0000010);
    check(!wake_o, "R8 masked out", wake_o, 0);
    tmr2_evt_i = 1; tick(1); tmr2_evt_i = 0;
    check(wake_o, "R8 wake with enables off", wake_o, 1);
    check(!irq_o, "R4 no irq without enables", irq_o, 0);

    // R7 clear
    clr_i = 1; clr_mask_i = 7'h7F; tick(1); clr_i = 0;
    check(flags_o == 0, "R7 clear all", flags_o, 0);

    // R5 priority with shared level, R6 accept
    src_en_i = 7'h7F; gie_set_i = 1;
    cmp_evt_i = 1; tmr3_evt_i = 1; ser_evt_i = 1; tick(1);
    gie_set_i = 0; cmp_evt_i = 0; tmr3_evt_i = 0; ser_evt_i = 0;
    check(irq_o && irq_vec_o == 3'd3, "R5 shared level", irq_vec_o, 3);
    ack_i = 1; tick(1); ack_i = 0;
    check(flags_o == 7'b1010000, "R6 comparator served first", flags_o, 7'b1010000);
    check(!gie_o, "R6 gie cleared", gie_o, 0);
    ack_i = 1; tick(1); ack_i = 0;
    check(flags_o == 7'b1010000, "R6 ack ignored without irq", flags_o, 7'b1010000);
    gie_set_i = 1; tick(1); gie_set_i = 0;
    check(irq_vec_o == 3'd3, "R5 timer3 on level 3", irq_vec_o, 3);
    ack_i = 1; gie_set_i = 1; tick(1); ack_i = 0; gie_set_i = 0;
    check(!gie_o && flags_o == 7'b1000000, "R9 accept beats set", {gie_o, flags_o}, 7'b1000000);
    gie_set_i = 1; tick(1); gie_set_i = 0;
    check(irq_vec_o == 3'd5, "R5 serial code", irq_vec_o, 5);
    ack_i = 1; tick(1); ack_i = 0;

    // R3 pin timing, rising edge ignored
    edge_pin0_i = 0; tick(2);
    check(!flags_o[0], "R3 not yet", flags_o[0], 0);
    tick(1);
    check(flags_o[0], "R3 falling edge latency", flags_o[0], 1);
    clr_i = 1; clr_mask_i = 7'h7F; tick(1); clr_i = 0;
    edge_pin0_i = 1; tick(6);
    check(flags_o == 0, "R3 rising edge ignored", flags_o, 0);
    edge_pin1_i = 0; tick(5);
    check(flags_o == 7'b0100000, "R3 pin1 flag", flags_o, 7'b0100000);
    gie_set_i = 1; tick(1); gie_set_i = 0;
    check(irq_vec_o == 3'd4, "R5 pin1 code", irq_vec_o, 4);
    edge_pin1_i = 1;

    // R7 set wins over clear
    clr_i = 1; clr_mask_i = 7'h7F; tmr0_evt_i = 1; tick(1); clr_i = 0; tmr0_evt_i = 0;
    check(flags_o == 7'b0000010, "R7 set wins", flags_o, 7'b0000010);

    // random mix checked by the model every cycle
    for (int i = 0; i < 4000; i++) begin
      tmr0_evt_i = ($urandom % 16) == 0;
      tmr2_evt_i = ($urandom % 16) == 0;
      cmp_evt_i  = ($urandom % 16) == 0;
      tmr3_evt_i = ($urandom % 16) == 0;
      ser_evt_i  = ($urandom % 16) == 0;
      if (($urandom % 7) == 0) edge_pin0_i = ~edge_pin0_i;
      if (($urandom % 9) == 0) edge_pin1_i = ~edge_pin1_i;
      if (($urandom % 50) == 0) src_en_i = 7'($urandom);
      if (($urandom % 40) == 0) wake_mask_i = 7'($urandom);
      gie_set_i = ($urandom % 4) == 0;
      ack_i     = ($urandom % 3) == 0;
      clr_i     = ($urandom % 30) == 0;
      clr_mask_i = 7'($urandom);
      tick(1);
    end
    tmr0_evt_i = 0; tmr2_evt_i = 0; cmp_evt_i = 0; tmr3_evt_i = 0; ser_evt_i = 0;
    gie_set_i = 0; ack_i = 0; clr_i = 0;
    tick(2);
    done = 1;
    summary();
    $finish;
  end
endmodule